// File: doc/BRIEF.md
# Reciprocal Frequency Counter Core

This block measures an unknown periodic signal against a fixed reference clock with a precision that does not depend on the input frequency. The host times a coarse gate. The real counting window is pulled onto rising edges of the measured signal. The window opens on the first measured rising edge seen while the gate is high. It closes on the first measured rising edge seen after the gate has dropped. During the window one counter adds up reference-clock cycles (Ns) and another adds up measured periods (Nx). Nx is therefore an exact period count, and the host computes the frequency as reference frequency × Nx / Ns.

All logic runs in the reference clock domain. The chosen input is a measured pin or a calibration clock. It passes through a two-flop synchronizer, and its rising edges are found by comparing it with a delayed copy. The coarse gate goes through a synchronizer of the same depth, so both signals keep their relative timing. The measured input must stay high for at least one reference cycle and low for at least one reference cycle. When counting stops, an active-low done flag drops and both counts freeze. The host then reads the two results as four 16-bit words through a select input.

Top module: `freq_recip_counter`

## Requirements
- R1: A one-cycle high pulse on `clr` zeroes both counts, returns the control to its waiting state and raises `done_n` on the following clock edge.
- R2: Raising `gate` does not start counting. Both counters start only at the next rising edge of the selected input that is seen while the gate is high. A gate pulse that contains no such edge leaves both counts at zero and `done_n` high.
- R3: While the window is open, Ns increases once per reference cycle. Nx increases once for each selected rising edge after the opening edge. For an input with a period of P reference cycles this gives Ns = Nx·P exactly.
- R4: After `gate` falls, counting continues up to and including the next selected rising edge, then stops. While the closing edge has not yet arrived, `done_n` stays high.
- R5: When counting stops, `done_n` goes low and stays low until `clr`. Both counts hold their values while `done_n` is low, even if more input edges arrive.
- R6: `rd_data` shows Ns[15:0] when `rd_sel`=0, Ns[31:16] when `rd_sel`=1, Nx[15:0] when `rd_sel`=2 and Nx[31:16] when `rd_sel`=3.
- R7: `src_sel`=0 measures `meas_in` and `src_sel`=1 measures `cal_in`. The input that is not selected has no effect on either count.
- R8: A counter that reaches all ones stays there instead of wrapping. The default width is 32 bits, which covers a 10 s gate at 50 MHz.
- R9: While `rst_n` is low at a clock edge, both counts are zero and `done_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; everything is registered on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Measurement clear pulse, active high |
| gate | input | 1 | Coarse gate timed by the host |
| src_sel | input | 1 | 0 = measured pin, 1 = calibration clock |
| meas_in | input | 1 | Unknown signal to be measured |
| cal_in | input | 1 | Calibration clock for self-test |
| rd_sel | input | 2 | Selects which counter half drives `rd_data` |
| done_n | output | 1 | Low once the window has closed |
| rd_data | output | 16 | Selected 16-bit half of Ns or Nx |

## Verification
The hardest states to reach are the ones where the coarse gate and the measured edges are out of step. In one case the gate drops long before the closing edge. In another the gate opens and closes between two edges. The bench builds the measured waveform step by step, so every gate change lands at a chosen phase of the input period. It covers opening mid-period, opening on an edge, a short gate with no edge inside it, and a slow input whose closing edge arrives well after the gate drop. A run of about 70,000 cycles pushes Ns past 16 bits. The same run drives an 8-bit instance into saturation on both counters.

// File: rtl/fcnt_pkg.sv
// Shared types for the reciprocal frequency counter.
package fcnt_pkg;
    // Read-select codes for the 16-bit result bus.
    typedef enum logic [1:0] {
        SEL_NS_LO = 2'd0,
        SEL_NS_HI = 2'd1,
        SEL_NX_LO = 2'd2,
        SEL_NX_HI = 2'd3
    } rd_sel_e;

    // Measurement control states.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/fc_sync.sv
// Multi-flop synchronizer into the reference clock domain.
// Assumes d is a level signal; output delayed by STAGES cycles.
module fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_gate_ctrl.sv
// Window control: opens on a measured rising edge while the synced gate
// is high, closes on the first measured rising edge after the gate drops,
// then holds until clear. Assumes edge_p is a single-cycle pulse.
module fc_gate_ctrl
    import fcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic gate_s,
    input  logic edge_p,
    output logic run,
    output logic done_n
);
    ctl_state_e state;

    // Advance the window state machine.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ST_WAIT;
        end else begin
            case (state)
                ST_WAIT: if (gate_s && edge_p)  state <= ST_RUN;
                ST_RUN:  if (!gate_s && edge_p) state <= ST_HOLD;
                default: state <= ST_HOLD;
            endcase
        end
    end

    assign run    = (state == ST_RUN);
    assign done_n = (state != ST_HOLD);

    // R5: done stays low until a clear.
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_n && !clr) |=> !done_n);

    // R1: clear returns the flag high.
    a_r1_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> done_n);
endmodule

// File: rtl/fc_counter.sv
// Saturating up-counter with synchronous clear.
// Assumes inc is sampled once per reference cycle.
module fc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    // Count up, stopping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)           count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    // R8: a saturated counter never wraps.
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP && !clr) |=> count == TOP);

    // R1: clear zeroes the count.
    a_r1_clear_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/freq_recip_counter.sv
// Reciprocal (equal-precision) frequency counter core.
// Counts reference cycles (Ns) and measured periods (Nx) over a window
// aligned to rising edges of the selected input. Assumes the selected
// input stays high and low for at least one reference cycle each.
module freq_recip_counter
    import fcnt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int RD_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            gate,
    input  logic            src_sel,
    input  logic            meas_in,
    input  logic            cal_in,
    input  logic [1:0]      rd_sel,
    output logic            done_n,
    output logic [RD_W-1:0] rd_data
);
    localparam int WIDE = 2 * RD_W;

    logic sel_raw, sel_s, sel_d, sel_rise, gate_s, run;
    logic [1:0]       cnt_inc;
    logic [CNT_W-1:0] cnt_q [2];
    logic [WIDE-1:0]  ns_w, nx_w;

    assign sel_raw = src_sel ? cal_in : meas_in;

    fc_sync #(.STAGES(SYNC_STAGES)) u_sync_sig (
        .clk(clk), .rst_n(rst_n), .d(sel_raw), .q(sel_s));
    fc_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
        .clk(clk), .rst_n(rst_n), .d(gate), .q(gate_s));

    // Delayed copy for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_d <= 1'b0;
        else        sel_d <= sel_s;
    end

    assign sel_rise = sel_s & ~sel_d;

    fc_gate_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .gate_s(gate_s),
        .edge_p(sel_rise), .run(run), .done_n(done_n));

    // Index 0 counts reference cycles, index 1 counts measured edges.
    assign cnt_inc[0] = run;
    assign cnt_inc[1] = run & sel_rise;

    for (genvar g = 0; g < 2; g++) begin : g_cnt
        fc_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(cnt_inc[g]), .count(cnt_q[g]));
    end

    assign ns_w = WIDE'(cnt_q[0]);
    assign nx_w = WIDE'(cnt_q[1]);

    // Drive the selected counter half.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            SEL_NS_LO: rd_data = ns_w[RD_W-1:0];
            SEL_NS_HI: rd_data = ns_w[WIDE-1:RD_W];
            SEL_NX_LO: rd_data = nx_w[RD_W-1:0];
            default:   rd_data = nx_w[WIDE-1:RD_W];
        endcase
    end

    // R2: the window opens only on a selected edge with the gate high.
    a_r2_open_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(sel_rise && gate_s));

    // R4: an edge after the gate drop closes the window and raises done.
    a_r4_close_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !gate_s && sel_rise && !clr) |=> (!run && !done_n));

    // R5: results are frozen while done is low.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_n && !clr) |=> ($stable(cnt_q[0]) && $stable(cnt_q[1])));
endmodule

// File: tb/tb_freq_recip_counter.sv
module tb_freq_recip_counter;
    logic clk = 1'b0;
    logic rst_n, clr, gate, src_sel, meas_in, cal_in;
    logic [1:0]  rd_sel;
    logic        done_n, done_n8;
    logic [15:0] rd_data, rd_data8;

    int n_chk = 0, n_fail = 0;
    int m_state, m_nx, step_no;
    logic prev_m;

    always #5 clk = ~clk;

    freq_recip_counter dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .gate(gate), .src_sel(src_sel),
        .meas_in(meas_in), .cal_in(cal_in), .rd_sel(rd_sel),
        .done_n(done_n), .rd_data(rd_data));

    freq_recip_counter #(.CNT_W(8)) dut8 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .gate(gate), .src_sel(src_sel),
        .meas_in(meas_in), .cal_in(cal_in), .rd_sel(rd_sel),
        .done_n(done_n8), .rd_data(rd_data8));

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one reference step of selected signal and gate; update model.
    task automatic step(input logic m, input logic g);
        @(negedge clk);
        step_no++;
        gate = g;
        if (src_sel) begin cal_in = m; meas_in = step_no[0]; end
        else         begin meas_in = m; cal_in = step_no[0]; end
        if (m && !prev_m) begin
            if (m_state == 0 && g) m_state = 1;
            else if (m_state == 1) begin
                m_nx++;
                if (!g) m_state = 2;
            end
        end
        prev_m = m;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v, output logic [15:0] v8);
        @(negedge clk);
        rd_sel = s;
        #1;
        v = rd_data; v8 = rd_data8;
    endtask

    task automatic do_clear();
        @(negedge clk); gate = 0; meas_in = 0; cal_in = 0; clr = 1;
        @(negedge clk); clr = 0;
        repeat (4) @(negedge clk);
        prev_m = 0; m_state = 0; m_nx = 0;
    endtask

    // Periodic input of period p; gate high for steps [on, off).
    task automatic run_periodic(input int p, input int on, input int off,
                                input int total, input int mid_chk);
        for (int i = 0; i < total; i++) begin
            step((i % p) < (p / 2), (i >= on) && (i < off));
            if (i == mid_chk) begin
                #1; check("R4 done_n high before closing edge", done_n, 1);
            end
        end
        repeat (4) step(1'b0, 1'b0);
    endtask

    task automatic check_result(input string tag, input int p);
        logic [15:0] v0, v1, v2, v3, d8;
        longint ns, nx, exp_ns, exp_nx;
        rd(2'd0, v0, d8); rd(2'd1, v1, d8); rd(2'd2, v2, d8); rd(2'd3, v3, d8);
        ns = {v1, v0}; nx = {v3, v2};
        exp_nx = (m_state == 2) ? m_nx : 0;
        exp_ns = (m_state == 2) ? longint'(m_nx) * p : 0;
        check({tag, " Nx"}, nx, exp_nx);
        check({tag, " Ns"}, ns, exp_ns);
        check({tag, " done_n"}, done_n, (m_state == 2) ? 0 : 1);
    endtask

    task automatic t_reset();
        logic [15:0] v, v8;
        rst_n = 0; clr = 0; gate = 0; src_sel = 0; meas_in = 0; cal_in = 0;
        rd_sel = 0; step_no = 0; prev_m = 0; m_state = 0; m_nx = 0;
        repeat (3) @(negedge clk);
        #1; check("R9 done_n in reset", done_n, 1);
        rst_n = 1;
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], v, v8); check("R9 count zero after reset", v, 0);
        end
    endtask

    task automatic t_basic();
        logic [15:0] a, b, d8;
        do_clear();
        run_periodic(10, 13, 95, 130, -1);
        check("R3 model closed", m_state, 2);
        check_result("R3 R6 mid-period open P=10", 10);
        rd(2'd0, a, d8);
        repeat (30) step((step_no % 6) < 3, 1'b0);
        rd(2'd0, b, d8);
        check("R5 Ns frozen after done", b, a);
        check("R5 done_n stays low", done_n, 0);
    endtask

    task automatic t_on_edge();
        do_clear();
        run_periodic(7, 14, 50, 80, -1);
        check_result("R3 open on edge P=7", 7);
    endtask

    task automatic t_slow_close();
        do_clear();
        run_periodic(40, 5, 50, 100, 70);
        check_result("R4 late closing edge P=40", 40);
    endtask

    task automatic t_no_edge();
        do_clear();
        run_periodic(40, 2, 10, 38, -1);
        check("R2 model never opened", m_state, 0);
        check_result("R2 gate without edge", 40);
    endtask

    task automatic t_clear();
        logic [15:0] v, v8;
        do_clear();
        run_periodic(6, 3, 30, 50, -1);
        check("R1 done before clear", done_n, 0);
        do_clear();
        #1; check("R1 done_n after clear", done_n, 1);
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], v, v8); check("R1 count zero after clear", v, 0);
        end
    endtask

    task automatic t_selftest();
        do_clear();
        src_sel = 1;
        run_periodic(4, 9, 60, 80, -1);
        check_result("R7 calibration source P=4", 4);
        do_clear();
        src_sel = 0;
    endtask

    task automatic t_long();
        logic [15:0] v, v8;
        longint exp_ns;
        do_clear();
        run_periodic(50, 20, 70000, 70070, -1);
        exp_ns = longint'(m_nx) * 50;
        check("R6 Ns crosses 16 bits", (exp_ns > 65535) ? 1 : 0, 1);
        check_result("R6 long gate P=50", 50);
        rd(2'd1, v, v8); check("R6 Ns high word", v, exp_ns >> 16);
        rd(2'd0, v, v8); check("R8 8-bit Ns saturates", v8, 255);
        rd(2'd2, v, v8); check("R8 8-bit Nx saturates", v8, 255);
        rd(2'd1, v, v8); check("R8 8-bit high word zero", v8, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_on_edge();
        t_slow_close();
        t_no_edge();
        t_clear();
        t_selftest();
        t_long();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule